// File: doc/BRIEF.md
# Double-Buffered Circular DMA Stream Engine

This block sequences the transfers of one DMA stream. Software programs a peripheral base address, two memory base pointers, an item count and a control word through a small write port. Once the stream is enabled it issues one single-beat transfer to a bus master port for every request it accepts. Each beat carries a source address, a destination address and the data size of each side. After each beat the count drops by one and the working addresses advance by the step chosen for each side.

The stream moves data from peripheral to memory, from memory to peripheral, or from memory to memory. In memory-to-memory mode it does not wait for a request and the peripheral address register acts as the source. Circular operation reloads the count and both working addresses from their programmed bases whenever the count reaches zero. Double buffering switches between the two memory pointers on every wrap. While the stream runs, software may rewrite the pointer that is idle. Three sticky flags report half-way, completion and error, and an interrupt line combines them with their enables.

Top module: `dma_stream_engine`

## Requirements
- R1: After reset all registers, working state and flags are zero: the stream is off, no bus request is raised, the remaining count is 0, the current target is 0 and the interrupt is low.
- R2: The write port decodes register 0 as control, 1 as item count (low 16 bits), 2 as peripheral base, 3 as memory pointer 0, 4 as memory pointer 1 and 5 as flag clear. Control bit 0 is the stream enable. Setting it loads the working count and addresses from their bases. bus_req is high only while the stream is on, the remaining count is nonzero and either dreq is high or the direction is memory-to-memory. Each cycle with bus_req and bus_ack both high is one beat and lowers the remaining count by one.
- R3: Control bits [2:1] select the direction: 0 moves peripheral to memory (source is the peripheral address), 1 moves memory to peripheral (source is the memory address), and 2 or 3 moves memory to memory (source is the peripheral address). Bits [10:9] give the peripheral size and bits [12:11] the memory size, where code 0 is 8 bits, code 1 is 16 bits and codes 2 and 3 are 32 bits. When bit 6 (peripheral increment) or bit 7 (memory increment) is set, that side's address advances by 1, 2 or 4 per beat to match its size.
- R4: When bit 6 and bit 8 (fixed step) are both set, the peripheral address advances by 4 per beat whatever the peripheral size.
- R5: Without circular mode (control bit 3), the beat that takes the count to zero sets the complete flag (flag bit 1) and clears the stream enable.
- R6: In circular mode, the beat that takes the count to zero sets the complete flag and reloads the count, the peripheral address and the memory address from their programmed values. The stream stays on.
- R7: Control bit 4 enables double buffering, which also forces circular mode on. Control bit 5 is the current target: written before enabling, it picks pointer 1 when set. It toggles on every wrap, and the next pass uses the other pointer.
- R8: While the stream runs in double-buffer mode, a write to the idle pointer is stored and takes effect at a later wrap. A write to the pointer that is the current target clears the enable and sets the error flag (flag bit 2).
- R9: Choosing memory-to-memory direction clears the circular and double-buffer bits in the same write. Memory-to-memory beats proceed without dreq.
- R10: While the stream is on, writes to count, peripheral base and control are ignored. The one exception is a control write with bit 0 low, which only stops the stream.
- R11: The half flag (flag bit 0) sets on the beat that brings the remaining count to the programmed count shifted right by one.
- R12: Flags stay set until a one is written to the matching bit of register 5, and a new set event in the same cycle wins over the clear. irq is the OR of each flag ANDed with its enable: control bit 13 enables half, bit 14 complete and bit 15 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | ADDR_W | Register write data |
| dreq | input | 1 | Transfer request from the peripheral |
| bus_ack | input | 1 | Bus master accepts the current beat |
| bus_req | output | 1 | Beat request to the bus master |
| bus_src | output | ADDR_W | Source address of the beat |
| bus_dst | output | ADDR_W | Destination address of the beat |
| bus_src_size | output | 2 | Source data size code |
| bus_dst_size | output | 2 | Destination data size code |
| stream_on | output | 1 | Stream enable state |
| cur_target | output | 1 | Current memory pointer selection |
| remaining | output | CNT_W | Items left in the current pass |
| flags | output | 3 | Sticky flags: half, complete, error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several things on every cycle. Memory-to-memory mode never holds a circular or double-buffer bit, and double buffering always implies circular mode. A beat request only appears while the stream runs with items left. The programmed count and peripheral base stay frozen while running. On a final beat the stream stops, or the count reloads and the target toggles. A write to the active pointer always raises the error and stops the stream. The flags follow their set and clear rules. The exact address sequences for each size and step option, the half-way point, acceptance of idle-pointer updates at later wraps, and the ignoring of writes while running can only be seen in the bench's scenarios, where they are compared against a bench-side model.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_COUNT = 3'd1;
    localparam logic [2:0] REG_PBASE = 3'd2;
    localparam logic [2:0] REG_MPTR0 = 3'd3;
    localparam logic [2:0] REG_MPTR1 = 3'd4;
    localparam logic [2:0] REG_FCLR  = 3'd5;

    localparam int NUM_FLAGS = 3;
    localparam int FLG_HALF  = 0;
    localparam int FLG_DONE  = 1;
    localparam int FLG_ERR   = 2;

    localparam logic [1:0] DIR_MEM_TO_PER = 2'd1;

    // control word, most significant field first (bit 15 down to bit 0)
    typedef struct packed {
        logic       err_ie;
        logic       done_ie;
        logic       half_ie;
        logic [1:0] msize;
        logic [1:0] psize;
        logic       pfixed;
        logic       minc;
        logic       pinc;
        logic       target;
        logic       dbuf;
        logic       circ;
        logic [1:0] dir;
        logic       en;
    } ctrl_t;

endpackage

// File: rtl/dma_step_calc.sv
module dma_step_calc #(
    parameter int ADDR_W = 32
) (
    input  logic              inc_en,
    input  logic              fixed4,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] step
);
    always_comb begin
        step = '0;
        if (inc_en) begin
            if (fixed4 || size[1]) begin
                step = ADDR_W'(4);
            end else if (size[0]) begin
                step = ADDR_W'(2);
            end else begin
                step = ADDR_W'(1);
            end
        end
    end
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    input  logic [NF-1:0] ie_i,
    output logic [NF-1:0] flags_o,
    output logic          irq_o
);
    logic [NF-1:0] flag_d, flag_q;

    for (genvar gi = 0; gi < NF; gi++) begin : g_flag
        assign flag_d[gi] = set_i[gi] | (flag_q[gi] & ~clr_i[gi]);

        assert_flag_set_R12 : assert property (@(posedge clk) disable iff (!rst_n)
            set_i[gi] |=> flags_o[gi]);
        assert_flag_w1c_R12 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[gi] && !set_i[gi]) |=> !flags_o[gi]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flags_o = flag_q;
    assign irq_o   = |(flag_q & ie_i);
endmodule

// File: rtl/dma_stream_engine.sv
module dma_stream_engine
    import dma_stream_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              dreq,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_src,
    output logic [ADDR_W-1:0] bus_dst,
    output logic [1:0]        bus_src_size,
    output logic [1:0]        bus_dst_size,
    output logic              stream_on,
    output logic              cur_target,
    output logic [CNT_W-1:0]  remaining,
    output logic [NUM_FLAGS-1:0] flags,
    output logic              irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  prog_cnt;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] pbase;
        logic [ADDR_W-1:0] m0;
        logic [ADDR_W-1:0] m1;
        logic [ADDR_W-1:0] pcur;
        logic [ADDR_W-1:0] mcur;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_ie;
    logic [ADDR_W-1:0]    pstep, mstep;
    logic                 mem2mem, mem2per, xfer_go, beat;

    dma_step_calc #(.ADDR_W(ADDR_W)) u_pstep (
        .inc_en (st_q.ctrl.pinc),
        .fixed4 (st_q.ctrl.pfixed),
        .size   (st_q.ctrl.psize),
        .step   (pstep)
    );

    dma_step_calc #(.ADDR_W(ADDR_W)) u_mstep (
        .inc_en (st_q.ctrl.minc),
        .fixed4 (1'b0),
        .size   (st_q.ctrl.msize),
        .step   (mstep)
    );

    assign mem2mem = st_q.ctrl.dir[1];
    assign mem2per = (st_q.ctrl.dir == DIR_MEM_TO_PER);
    assign xfer_go = st_q.ctrl.en && (st_q.cnt != '0) && (dreq || mem2mem);
    assign beat    = xfer_go && bus_ack;
    assign flag_ie = {st_q.ctrl.err_ie, st_q.ctrl.done_ie, st_q.ctrl.half_ie};

    always_comb begin
        ctrl_t            nc;
        logic [CNT_W-1:0] cnt_nx;
        st_d     = st_q;
        flag_set = '0;
        flag_clr = '0;
        nc       = st_q.ctrl;
        cnt_nx   = st_q.cnt - CNT_W'(1);

        // beat bookkeeping: count, address advance, wrap handling
        if (beat) begin
            if (cnt_nx == (st_q.prog_cnt >> 1)) begin
                flag_set[FLG_HALF] = 1'b1;
            end
            if (cnt_nx == '0) begin
                flag_set[FLG_DONE] = 1'b1;
                if (st_q.ctrl.circ) begin
                    st_d.cnt  = st_q.prog_cnt;
                    st_d.pcur = st_q.pbase;
                    if (st_q.ctrl.dbuf) begin
                        st_d.ctrl.target = ~st_q.ctrl.target;
                        st_d.mcur = st_q.ctrl.target ? st_q.m0 : st_q.m1;
                    end else begin
                        st_d.mcur = st_q.m0;
                    end
                end else begin
                    st_d.ctrl.en = 1'b0;
                    st_d.cnt     = '0;
                    st_d.pcur    = st_q.pcur + pstep;
                    st_d.mcur    = st_q.mcur + mstep;
                end
            end else begin
                st_d.cnt  = cnt_nx;
                st_d.pcur = st_q.pcur + pstep;
                st_d.mcur = st_q.mcur + mstep;
            end
        end

        // register writes
        if (wr_en) begin
            case (wr_addr)
                REG_CTRL: begin
                    if (!st_q.ctrl.en) begin
                        nc = ctrl_t'(wr_data[CTRL_W-1:0]);
                        if (nc.dir[1]) begin
                            nc.circ = 1'b0;
                            nc.dbuf = 1'b0;
                        end
                        if (nc.dbuf) begin
                            nc.circ = 1'b1;
                        end
                        st_d.ctrl = nc;
                        if (nc.en) begin
                            st_d.cnt  = st_q.prog_cnt;
                            st_d.pcur = st_q.pbase;
                            st_d.mcur = (nc.dbuf && nc.target) ? st_q.m1 : st_q.m0;
                        end
                    end else if (!wr_data[0]) begin
                        st_d.ctrl.en = 1'b0;
                    end
                end
                REG_COUNT: begin
                    if (!st_q.ctrl.en) begin
                        st_d.prog_cnt = wr_data[CNT_W-1:0];
                    end
                end
                REG_PBASE: begin
                    if (!st_q.ctrl.en) begin
                        st_d.pbase = wr_data;
                    end
                end
                REG_MPTR0: begin
                    if (!st_q.ctrl.en) begin
                        st_d.m0 = wr_data;
                    end else if (st_q.ctrl.dbuf) begin
                        if (st_q.ctrl.target) begin
                            st_d.m0 = wr_data;
                        end else begin
                            st_d.ctrl.en      = 1'b0;
                            flag_set[FLG_ERR] = 1'b1;
                        end
                    end
                end
                REG_MPTR1: begin
                    if (!st_q.ctrl.en) begin
                        st_d.m1 = wr_data;
                    end else if (st_q.ctrl.dbuf) begin
                        if (!st_q.ctrl.target) begin
                            st_d.m1 = wr_data;
                        end else begin
                            st_d.ctrl.en      = 1'b0;
                            flag_set[FLG_ERR] = 1'b1;
                        end
                    end
                end
                REG_FCLR: begin
                    flag_clr = wr_data[NUM_FLAGS-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dma_flag_bank #(.NF(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .ie_i    (flag_ie),
        .flags_o (flags),
        .irq_o   (irq)
    );

    assign bus_req      = xfer_go;
    assign bus_src      = mem2per ? st_q.mcur : st_q.pcur;
    assign bus_dst      = mem2per ? st_q.pcur : st_q.mcur;
    assign bus_src_size = mem2per ? st_q.ctrl.msize : st_q.ctrl.psize;
    assign bus_dst_size = mem2per ? st_q.ctrl.psize : st_q.ctrl.msize;
    assign stream_on    = st_q.ctrl.en;
    assign cur_target   = st_q.ctrl.target;
    assign remaining    = st_q.cnt;

    assert_req_gate_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (stream_on && remaining != '0));
    assert_stop_at_end_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && remaining == CNT_W'(1) && !st_q.ctrl.circ && !wr_en)
        |=> (!stream_on && flags[FLG_DONE]));
    assert_reload_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && remaining == CNT_W'(1) && st_q.ctrl.circ)
        |=> (remaining == $past(st_q.prog_cnt)));
    assert_dbuf_forces_circ_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.dbuf |-> st_q.ctrl.circ);
    assert_target_toggle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && remaining == CNT_W'(1) && st_q.ctrl.dbuf)
        |=> (cur_target != $past(cur_target)));
    assert_active_ptr_err_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && stream_on && st_q.ctrl.dbuf &&
         ((wr_addr == REG_MPTR0 && !cur_target) || (wr_addr == REG_MPTR1 && cur_target)))
        |=> (!stream_on && flags[FLG_ERR]));
    assert_m2m_no_circ_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.dir[1] |-> (!st_q.ctrl.circ && !st_q.ctrl.dbuf));
    assert_frozen_cfg_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (stream_on && $past(stream_on)) |-> ($stable(st_q.prog_cnt) && $stable(st_q.pbase)));
endmodule

// File: tb/dma_stream_engine_test.sv
`timescale 1ns/1ps
module dma_stream_engine_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        dreq;
    logic        bus_ack;
    logic        bus_req;
    logic [31:0] bus_src, bus_dst;
    logic [1:0]  bus_src_size, bus_dst_size;
    logic        stream_on, cur_target;
    logic [15:0] remaining;
    logic [2:0]  flags;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dma_stream_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dreq(dreq), .bus_ack(bus_ack), .bus_req(bus_req), .bus_src(bus_src),
        .bus_dst(bus_dst), .bus_src_size(bus_src_size), .bus_dst_size(bus_dst_size),
        .stream_on(stream_on), .cur_target(cur_target), .remaining(remaining),
        .flags(flags), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(bit en, logic [1:0] dir, bit circ, bit dbuf, bit tgt,
                                       bit pinc, bit minc, bit pfix, logic [1:0] psz,
                                       logic [1:0] msz, logic [2:0] ie);
        return {16'b0, ie[2], ie[1], ie[0], msz, psz, pfix, minc, pinc, tgt, dbuf, circ, dir, en};
    endfunction

    function automatic logic [31:0] step_of(bit inc, bit fix, logic [1:0] sz);
        if (!inc) return 32'd0;
        if (fix || sz >= 2) return 32'd4;
        return (sz == 2'd1) ? 32'd2 : 32'd1;
    endfunction

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; dreq = 1'b0; bus_ack = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one beat with dreq high: check addresses before the edge, return at next negedge
    task automatic beat(string req, logic [31:0] es, logic [31:0] ed);
        dreq = 1'b1;
        #1;
        chk({req, " bus_req"}, {31'b0, bus_req}, 32'd1);
        chk({req, " src"}, bus_src, es);
        chk({req, " dst"}, bus_dst, ed);
        @(negedge clk);
        dreq = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        do_reset();

        // R1: reset state
        chk("R1 stream_on", {31'b0, stream_on}, 0);
        chk("R1 bus_req", {31'b0, bus_req}, 0);
        chk("R1 remaining", {16'b0, remaining}, 0);
        chk("R1 flags", {29'b0, flags}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 target", {31'b0, cur_target}, 0);

        // random single-pass scenarios: R2 R3 R4 R5 R11 R12
        for (int s = 0; s < 25; s++) begin
            logic [1:0]  dir, psz, msz;
            logic [2:0]  ie, efl;
            bit          pinc, minc, pfix;
            int          n;
            logic [31:0] pa, ma, ps, ms;
            dir  = 2'($urandom_range(0, 1));
            psz  = 2'($urandom_range(0, 2));
            msz  = 2'($urandom_range(0, 2));
            pinc = 1'($urandom); minc = 1'($urandom); pfix = 1'($urandom);
            ie   = 3'($urandom);
            n    = $urandom_range(1, 24);
            pa   = $urandom & 32'hFFFF_FFF0;
            ma   = $urandom & 32'hFFFF_FFF0;
            ps   = step_of(pinc, pfix, psz);
            ms   = step_of(minc, 1'b0, msz);
            wr(3'd1, n);
            wr(3'd2, pa);
            wr(3'd3, ma);
            wr(3'd5, 32'd7);
            wr(3'd0, cw(1, dir, 0, 0, 0, pinc, minc, pfix, psz, msz, ie));
            #1;
            chk("R2 no request without dreq", {31'b0, bus_req}, 0);
            chk("R3 source size", {30'b0, bus_src_size}, {30'b0, (dir == 2'd1) ? msz : psz});
            efl = 3'b0;
            for (int k = 0; k < n; k++) begin
                beat("R3 R4 random beat", (dir == 2'd1) ? ma : pa, (dir == 2'd1) ? pa : ma);
                pa = pa + ps; ma = ma + ms;
                if (n - k - 1 == n / 2) efl[0] = 1'b1;
                if (n - k - 1 == 0) efl[1] = 1'b1;
                chk("R2 remaining", {16'b0, remaining}, n - k - 1);
                chk("R11 flags", {29'b0, flags}, {29'b0, efl});
                chk("R12 irq", {31'b0, irq}, {31'b0, |(efl & ie)});
            end
            chk("R5 stopped at zero", {31'b0, stream_on}, 0);
        end

        // R6 circular reload with fixed peripheral step (R4), R11 half point
        do_reset();
        wr(3'd1, 3); wr(3'd2, 32'h40); wr(3'd3, 32'h100);
        wr(3'd0, cw(1, 0, 1, 0, 0, 1, 1, 1, 0, 2, 0));
        #1;
        chk("R2 gated by dreq", {31'b0, bus_req}, 0);
        beat("R4 circ b0", 32'h40, 32'h100);
        chk("R11 no half yet", {29'b0, flags}, 0);
        beat("R4 circ b1", 32'h44, 32'h104);
        chk("R11 half at 1 of 3", {29'b0, flags}, 1);
        beat("R4 circ b2", 32'h48, 32'h108);
        chk("R6 count reloaded", {16'b0, remaining}, 3);
        chk("R6 still on", {31'b0, stream_on}, 1);
        chk("R6 done flag", {29'b0, flags}, 3);
        beat("R6 bases reloaded", 32'h40, 32'h100);

        // R10 writes ignored while running
        wr(3'd1, 50); wr(3'd2, 32'h999);
        wr(3'd0, cw(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        chk("R10 count write ignored", {16'b0, remaining}, 2);
        beat("R10 config writes ignored", 32'h44, 32'h104);
        beat("R10 increment still on", 32'h48, 32'h108);
        chk("R10 reload uses old count", {16'b0, remaining}, 3);
        wr(3'd0, 32'd0);
        chk("R10 disable by clearing enable", {31'b0, stream_on}, 0);

        // R7 R8 R12 double buffering
        do_reset();
        wr(3'd1, 2); wr(3'd2, 32'h10); wr(3'd3, 32'h200); wr(3'd4, 32'h300);
        wr(3'd0, cw(1, 0, 0, 1, 1, 0, 1, 0, 0, 0, 3'b100));
        chk("R7 preset target", {31'b0, cur_target}, 1);
        beat("R7 pointer 1 first", 32'h10, 32'h300);
        beat("R7 pointer 1 second", 32'h10, 32'h301);
        chk("R7 target toggled", {31'b0, cur_target}, 0);
        chk("R7 circular forced", {31'b0, stream_on}, 1);
        wr(3'd4, 32'h400);
        chk("R8 idle write keeps running", {31'b0, stream_on}, 1);
        chk("R8 no error", {31'b0, flags[2]}, 0);
        beat("R7 pointer 0", 32'h10, 32'h200);
        beat("R7 pointer 0 next", 32'h10, 32'h201);
        beat("R8 updated idle pointer used", 32'h10, 32'h400);
        wr(3'd4, 32'h500);
        chk("R8 active write stops", {31'b0, stream_on}, 0);
        chk("R8 error flag", {31'b0, flags[2]}, 1);
        chk("R12 irq from error", {31'b0, irq}, 1);
        wr(3'd5, 32'd4);
        chk("R12 error cleared", {31'b0, flags[2]}, 0);
        chk("R12 done kept", {31'b0, flags[1]}, 1);
        chk("R12 irq low", {31'b0, irq}, 0);

        // R9 memory to memory
        do_reset();
        wr(3'd1, 2); wr(3'd2, 32'h1000); wr(3'd3, 32'h2000);
        wr(3'd0, cw(0, 2, 1, 1, 0, 1, 1, 0, 2, 2, 0));
        wr(3'd0, cw(1, 2, 1, 1, 0, 1, 1, 0, 2, 2, 0));
        dreq = 1'b0;
        #1;
        chk("R9 runs without dreq", {31'b0, bus_req}, 1);
        chk("R9 src b0", bus_src, 32'h1000);
        chk("R9 dst b0", bus_dst, 32'h2000);
        @(negedge clk); #1;
        chk("R9 src b1", bus_src, 32'h1004);
        chk("R9 dst b1", bus_dst, 32'h2004);
        @(negedge clk); #1;
        chk("R9 circular cleared so stops", {31'b0, stream_on}, 0);
        chk("R9 done", {31'b0, flags[1]}, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule